// File: doc/BRIEF.md
# Dual-Flag Two's-Complement Adder-Subtractor

This block adds or subtracts two unsigned-or-signed binary operands of a parameter width and returns the wrapped result together with two independent overflow indications. One indicates that the operation left the unsigned range. The other indicates that it left the two's-complement range. A single select input picks the operation. Subtraction reuses the same carry chain: each bit of the second operand is inverted by the select, and the select is also injected as the initial carry, so the chain computes A + ~B + 1.

The block is purely combinational and has no clock, reset or state. A datapath that needs both signed and unsigned comparison information can use it directly. The unsigned flag is the raw carry out of the top bit. The signed flag is that carry exclusive-ORed with the carry entering the top bit. Because there are no states, the block has no state machine and no transitions. Both outputs and flags follow the inputs within the same evaluation.

Top module: `addsub_dual_ovf`

## Requirements
- R1: With sub_sel = 0 (addition), result equals (op_a + op_b) modulo 2^WIDTH, whatever the flags show.
- R2: With sub_sel = 1 (subtraction), result equals (op_a - op_b) modulo 2^WIDTH, whatever the flags show.
- R3: With sub_sel = 0, carry_flag is 1 exactly when the unsigned sum op_a + op_b is 2^WIDTH or more.
- R4: With sub_sel = 1, carry_flag is the uninverted carry out of op_a + ~op_b + 1, so it is 1 exactly when op_a >= op_b as unsigned values.
- R5: sign_flag is 1 exactly when the selected operation, applied to op_a and op_b read as two's-complement values, gives a value outside [-2^(WIDTH-1), 2^(WIDTH-1) - 1].
- R6: At WIDTH = 4, adding 0100 and 0101 gives result 1001, carry_flag 0 and sign_flag 1.
- R7: At WIDTH = 4, adding 1100 and 1101 gives result 1001, carry_flag 1 and sign_flag 0.
- R8: Subtracting op_b = 0 returns result = op_a with carry_flag 1 and sign_flag 0, for every op_a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand (minuend when subtracting) |
| op_b | input | WIDTH | Second operand (subtrahend when subtracting) |
| sub_sel | input | 1 | 0 selects addition, 1 selects subtraction |
| result | output | WIDTH | Low WIDTH bits of the selected operation |
| carry_flag | output | 1 | Carry out of the most significant bit (unsigned overflow on add, no-borrow on subtract) |
| sign_flag | output | 1 | Two's-complement overflow: top carry out XOR carry into the top bit |

## Verification
The bound checker compares the result and both flags with wide integer arithmetic on the ports whenever any input changes. That covers R1 to R5 for whatever operand values appear, and it treats addition and subtraction as separate cases. The two fixed operand pairs of R6 and R7 can only be confirmed by the bench. So can the subtract-zero corner of R8 and the exhaustive sweep over every operand pair and both selections at the default width. These checks are scored against values the bench computes from the requirements alone.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    // Operation encoding carried on sub_sel
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } addsub_op_e;

endpackage

// File: rtl/addsub_bcond.sv
module addsub_bcond
    import addsub_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] op_b,
    input  addsub_op_e       op_kind,
    output logic [WIDTH-1:0] b_eff,
    output logic             carry_seed
);

    logic invert;

    always_comb begin
        unique case (op_kind)
            OP_ADD:  invert = 1'b0;
            OP_SUB:  invert = 1'b1;
            default: invert = 1'b0;
        endcase
    end

    // Per-bit conditional inversion of the second operand
    for (genvar i = 0; i < WIDTH; i++) begin : g_inv
        assign b_eff[i] = op_b[i] ^ invert;
    end

    // The +1 of the two's-complement negation enters as the chain's carry-in
    assign carry_seed = invert;

endmodule

// File: rtl/addsub_fa_cell.sv
module addsub_fa_cell (
    input  logic x_in,
    input  logic y_in,
    input  logic c_in,
    output logic s_out,
    output logic c_out
);

    logic half;

    assign half  = x_in ^ y_in;
    assign s_out = half ^ c_in;
    assign c_out = (x_in & y_in) | (half & c_in);

endmodule

// File: rtl/addsub_chain.sv
module addsub_chain #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_vec,
    input  logic [WIDTH-1:0] y_vec,
    input  logic             c_seed,
    output logic [WIDTH-1:0] sum_vec,
    output logic             c_top,
    output logic             c_into_msb
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] c_link;

    assign c_link[0] = c_seed;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        addsub_fa_cell u_cell (
            .x_in  (x_vec[i]),
            .y_in  (y_vec[i]),
            .c_in  (c_link[i]),
            .s_out (sum_vec[i]),
            .c_out (c_link[i+1])
        );
    end

    assign c_top      = c_link[WIDTH];
    assign c_into_msb = c_link[MSB];

endmodule

// File: rtl/addsub_flags.sv
module addsub_flags (
    input  logic c_top,
    input  logic c_into_msb,
    output logic unsigned_ovf,
    output logic signed_ovf
);

    // Raw carry out, never inverted, also during subtraction
    assign unsigned_ovf = c_top;
    // The top bit's carry-in and carry-out disagree only on signed overflow
    assign signed_ovf   = c_top ^ c_into_msb;

endmodule

// File: rtl/addsub_dual_ovf.sv
module addsub_dual_ovf
    import addsub_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             sub_sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_flag,
    output logic             sign_flag
);

    addsub_op_e       op_kind;
    logic [WIDTH-1:0] b_eff;
    logic             carry_seed;
    logic             c_top;
    logic             c_into_msb;

    assign op_kind = addsub_op_e'(sub_sel);

    addsub_bcond #(.WIDTH(WIDTH)) u_bcond (
        .op_b       (op_b),
        .op_kind    (op_kind),
        .b_eff      (b_eff),
        .carry_seed (carry_seed)
    );

    addsub_chain #(.WIDTH(WIDTH)) u_chain (
        .x_vec      (op_a),
        .y_vec      (b_eff),
        .c_seed     (carry_seed),
        .sum_vec    (result),
        .c_top      (c_top),
        .c_into_msb (c_into_msb)
    );

    addsub_flags u_flags (
        .c_top        (c_top),
        .c_into_msb   (c_into_msb),
        .unsigned_ovf (carry_flag),
        .signed_ovf   (sign_flag)
    );

endmodule

// File: rtl/addsub_dual_ovf_chk.sv
module addsub_dual_ovf_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             sub_sel,
    input logic [WIDTH-1:0] result,
    input logic             carry_flag,
    input logic             sign_flag
);

    logic [WIDTH:0] wide_sum;
    logic [WIDTH:0] wide_diff;
    logic [WIDTH:0] sext_sum;
    logic [WIDTH:0] sext_diff;

    always_comb begin
        wide_sum  = {1'b0, op_a} + {1'b0, op_b};
        wide_diff = {1'b0, op_a} - {1'b0, op_b};
        sext_sum  = {op_a[WIDTH-1], op_a} + {op_b[WIDTH-1], op_b};
        sext_diff = {op_a[WIDTH-1], op_a} - {op_b[WIDTH-1], op_b};

        // R1
        add_sum_chk: assert (sub_sel || result == wide_sum[WIDTH-1:0])
            else $error("add_sum_chk");
        // R2
        sub_diff_chk: assert (!sub_sel || result == wide_diff[WIDTH-1:0])
            else $error("sub_diff_chk");
        // R3
        add_carry_chk: assert (sub_sel || carry_flag == wide_sum[WIDTH])
            else $error("add_carry_chk");
        // R4
        sub_carry_chk: assert (!sub_sel || carry_flag == !wide_diff[WIDTH])
            else $error("sub_carry_chk");
        // R5
        add_sign_chk: assert (sub_sel ||
                              sign_flag == (sext_sum[WIDTH] ^ sext_sum[WIDTH-1]))
            else $error("add_sign_chk");
        // R5
        sub_sign_chk: assert (!sub_sel ||
                              sign_flag == (sext_diff[WIDTH] ^ sext_diff[WIDTH-1]))
            else $error("sub_sign_chk");
    end

endmodule

bind addsub_dual_ovf addsub_dual_ovf_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a       (op_a),
    .op_b       (op_b),
    .sub_sel    (sub_sel),
    .result     (result),
    .carry_flag (carry_flag),
    .sign_flag  (sign_flag)
);

// File: tb/addsub_dual_ovf_tb.sv
module addsub_dual_ovf_tb;

    localparam int W = 4;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         s;
        logic [W-1:0] ef;
        logic         eu;
        logic         es;
        string        tf;
        string        tu;
        string        ts;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         sub_sel = 1'b0;
    logic [W-1:0] result;
    logic         carry_flag;
    logic         sign_flag;

    int    checks = 0;
    int    errors = 0;
    int    wd_cnt = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    always #5 clk = ~clk;

    addsub_dual_ovf #(.WIDTH(W)) u_dut (
        .op_a       (op_a),
        .op_b       (op_b),
        .sub_sel    (sub_sel),
        .result     (result),
        .carry_flag (carry_flag),
        .sign_flag  (sign_flag)
    );

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h s=%0b actual=%0b expected=%0b",
                     tag, op_a, op_b, sub_sel, act, exp);
        end
    endtask

    task automatic check_vec(input string tag, input logic [W-1:0] act,
                             input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h s=%0b actual=%h expected=%h",
                     tag, op_a, op_b, sub_sel, act, exp);
        end
    endtask

    // Driver: apply stimulus after the rising edge and push the expectation
    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic s, input string grp);
        item_t it;
        int ua, ub, sa, sb, r;
        ua = int'(a);
        ub = int'(b);
        sa = a[W-1] ? ua - (1 << W) : ua;
        sb = b[W-1] ? ub - (1 << W) : ub;
        r  = s ? sa - sb : sa + sb;
        it.a  = a;
        it.b  = b;
        it.s  = s;
        it.ef = s ? W'(ua - ub) : W'(ua + ub);
        it.eu = s ? (ua >= ub) : ((ua + ub) >= (1 << W));
        it.es = (r < -(1 << (W - 1))) || (r > ((1 << (W - 1)) - 1));
        if (grp == "") begin
            it.tf = s ? "R2" : "R1";
            it.tu = s ? "R4" : "R3";
            it.ts = "R5";
        end else begin
            it.tf = grp;
            it.tu = grp;
            it.ts = grp;
        end
        @(posedge clk);
        op_a    <= a;
        op_b    <= b;
        sub_sel <= s;
        sb_q.push_back(it);
    endtask

    // Monitor: pop and compare between rising edges
    initial begin
        item_t it;
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check_vec(it.tf, result, it.ef);
                check_bit(it.tu, carry_flag, it.eu);
                check_bit(it.ts, sign_flag, it.es);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        wd_cnt <= wd_cnt + 1;
        if (wd_cnt > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // Zero inputs while reset is held: R1 gives a zero sum and clear flags
        check_vec("R1 idle", result, 4'h0);
        check_bit("R3 idle", carry_flag, 1'b0);
        check_bit("R5 idle", sign_flag, 1'b0);
        rst_n = 1'b1;

        // R6 and R7: the two fixed overflow examples
        drive(4'b0100, 4'b0101, 1'b0, "R6");
        drive(4'b1100, 4'b1101, 1'b0, "R7");

        // R8: subtracting zero leaves A, sets the carry, clears the sign flag
        for (int a = 0; a < (1 << W); a++) begin
            drive(W'(a), 4'h0, 1'b1, "R8");
        end

        // Exhaustive sweep for R1..R5
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    drive(W'(a), W'(b), s[0], "");
                end
            end
        end

        repeat (3) @(posedge clk);
        if (sb_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R1 scoreboard actual=%0d expected=0", sb_q.size());
        end
        finish_run();
    end

endmodule